// File: doc/BRIEF.md
# Transmit FIFO with Underrun Replay

This block is the word buffer between a processor and a serial audio transmitter. The processor pushes data words into a 16-entry circular store, one per write strobe. The serial shifter pulls one word each time its assigned slot comes up, and the word shows up on a registered output one clock after the pull. A single flag records whether the most recent access was a write or a read. That flag lets the block tell a full store from an empty one while keeping both pointers at their natural 4-bit width.

If the shifter pulls while the store is empty, the pull is an underrun. The read position first advances and then steps back by one, which is an add of 15 modulo 16, so its net position is unchanged. The output keeps presenting the word sent last, so the line repeats that word and does not send stale or undefined data. A sticky underrun flag is raised, and no interrupt is raised for that pull. Processor writes are never blocked: a write into a full store overwrites the oldest unread word. The transmit interrupt is a one-cycle pulse that follows each successful pull after which the store is not full.

Top module: `tx_fifo_replay`

## Requirements
- R1: After reset, empty is 1, full is 0, underrun is 0, irq is 0 and pull_data is 0.
- R2: A write stores wr_data at the write position, and that position then advances by one modulo 16. A successful pull presents the word at the read position on pull_data one clock later and advances the read position by one, so words come out in the order they were written.
- R3: empty is 1 exactly when the read and write positions are equal and the last access was a pull. full and empty are never 1 together.
- R4: full is 1 exactly when the positions are equal and the last access was a write. For example, full is 1 after 16 writes from the empty state with no pulls.
- R5: A pull while empty is an underrun. pull_data keeps its previous value. The read position advances and then steps back by one (adds 15 modulo 16), so the next word written is the next word a later pull delivers.
- R6: An underrun sets the underrun output to 1, and it stays 1 until reset.
- R7: irq is 1 for exactly one cycle after a successful pull when the store is not full after that cycle's accesses. irq is 0 after an underrun pull and 0 when no pull took place.
- R8: A write while full is not blocked. It overwrites the entry at the write position, which is the oldest unread word, and advances the write position. After it, neither full nor empty is 1.
- R9: When a write and a pull fall in the same cycle, both are carried out. The pull sees the state from before the write. The last-access flag records a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 16 | Word to store |
| pull | input | 1 | Shifter request for the next word |
| pull_data | output | 16 | Word for the shifter, valid the cycle after a pull |
| full | output | 1 | Positions equal and last access was a write |
| empty | output | 1 | Positions equal and last access was a pull |
| underrun | output | 1 | Sticky: a pull hit an empty store |
| irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
Directed runs fill the store to full and then drain it. This separates write order from read order and shows the full and empty flags changing on the exact access. Pulls on an empty store, followed by a write and a pull, distinguish a held output with an unchanged read position from a replay taken from the wrong entry. Writes into a full store and simultaneous write-and-pull cycles at both the empty and the full boundary show whether the last-access flag gives the write priority. Long seeded random traffic at several write-to-pull ratios is compared cycle by cycle with a reference model of the pointer rules, which catches wrap-around and interrupt timing errors.

// File: rtl/txf_pkg.sv
package txf_pkg;
    // Kind of the most recent access; used to resolve equal pointers.
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;
endpackage

// File: rtl/txf_store.sv
module txf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read is combinational so a same-cycle write is seen only afterwards.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
    import txf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              pull,
    input  logic [DATA_W-1:0] rd_word,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] pull_data,
    output logic              full,
    output logic              empty,
    output logic              underrun,
    output logic              irq
);
    localparam logic [PTR_W-1:0] STEP_BACK = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0]  rp;
        logic [PTR_W-1:0]  wp;
        acc_e              last;
        logic [DATA_W-1:0] data;
        logic              und;
        logic              irq;
    } state_t;

    state_t st_q, st_d;
    logic   ptr_eq;
    logic   next_full;

    always_comb begin
        st_d   = st_q;
        ptr_eq = (st_q.rp == st_q.wp);
        empty  = ptr_eq && (st_q.last == ACC_READ);
        full   = ptr_eq && (st_q.last == ACC_WRITE);

        if (pull) begin
            st_d.rp = st_q.rp + ONE;
            if (empty) begin
                // Undo the advance: previous word is presented again.
                st_d.rp  = st_d.rp + STEP_BACK;
                st_d.und = 1'b1;
            end else begin
                st_d.data = rd_word;
            end
        end

        if (wr_en) begin
            st_d.wp = st_q.wp + ONE;
        end

        if (wr_en) begin
            st_d.last = ACC_WRITE;
        end else if (pull) begin
            st_d.last = ACC_READ;
        end

        next_full = (st_d.rp == st_d.wp) && (st_d.last == ACC_WRITE);
        st_d.irq  = pull && !empty && !next_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rp: '0, wp: '0, last: ACC_READ, data: '0, und: 1'b0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr   = st_q.wp;
    assign rd_addr   = st_q.rp;
    assign pull_data = st_q.data;
    assign underrun  = st_q.und;
    assign irq       = st_q.irq;

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R3
    AST_WP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.wp == $past(st_q.wp) + ONE)); // R2
    AST_FULL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_en)); // R4
    AST_REPLAY_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && empty) |=> $stable(pull_data)); // R5
    AST_REPLAY_KEEPS_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && empty) |=> $stable(st_q.rp)); // R5
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R6
    AST_NO_IRQ_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && empty) |=> !irq); // R7
    AST_IRQ_NEEDS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        !pull |=> !irq); // R7
endmodule

// File: rtl/tx_fifo_replay.sv
module tx_fifo_replay #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pull,
    output logic [DATA_W-1:0] pull_data,
    output logic              full,
    output logic              empty,
    output logic              underrun,
    output logic              irq
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]  wr_addr;
    logic [PTR_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_word;

    txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    txf_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .pull      (pull),
        .rd_word   (rd_word),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .pull_data (pull_data),
        .full      (full),
        .empty     (empty),
        .underrun  (underrun),
        .irq       (irq)
    );
endmodule

// File: tb/tb_tx_fifo_replay.sv
module tb_tx_fifo_replay;
    localparam int DW  = 16;
    localparam int DEP = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          pull;
    logic [DW-1:0] pull_data;
    logic          full, empty, underrun, irq;

    always #5 clk = ~clk;

    tx_fifo_replay #(.DATA_W(DW), .DEPTH(DEPTH_P)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pull(pull),
        .pull_data(pull_data), .full(full), .empty(empty), .underrun(underrun), .irq(irq)
    );
    localparam int DEPTH_P = DEP;

    // Reference model of the requirements
    logic [DW-1:0] m_mem [DEP];
    int            m_rp, m_wp;
    bit            m_lw;
    logic [DW-1:0] m_data;
    bit            m_und, m_irq;

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_empty();
        return (m_rp == m_wp) && !m_lw;
    endfunction

    function automatic bit m_full();
        return (m_rp == m_wp) && m_lw;
    endfunction

    task automatic model_reset();
        m_rp = 0; m_wp = 0; m_lw = 0; m_data = '0; m_und = 0; m_irq = 0;
    endtask

    task automatic model_step(input bit we, input logic [DW-1:0] wd, input bit pl);
        bit was_empty;
        was_empty = m_empty();
        m_irq = 0;
        if (pl) begin
            if (was_empty) m_und = 1;
            else begin
                m_data = m_mem[m_rp];
                m_rp = (m_rp + 1) % DEP;
            end
        end
        if (we) begin
            m_mem[m_wp] = wd;
            m_wp = (m_wp + 1) % DEP;
        end
        if (we) m_lw = 1;
        else if (pl) m_lw = 0;
        m_irq = pl && !was_empty && !m_full();
    endtask

    task automatic compare(input string tag);
        chk(pull_data === m_data, {tag, " pull_data R2"}, pull_data, m_data);
        chk(empty === m_empty(), {tag, " empty R3"}, DW'(empty), DW'(m_empty()));
        chk(full === m_full(), {tag, " full R4"}, DW'(full), DW'(m_full()));
        chk(underrun === m_und, {tag, " underrun R6"}, DW'(underrun), DW'(m_und));
        chk(irq === m_irq, {tag, " irq R7"}, DW'(irq), DW'(m_irq));
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input bit we, input logic [DW-1:0] wd, input bit pl, input string tag);
        wr_en = we; wr_data = wd; pull = pl;
        model_step(we, wd, pl);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; pull = 0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; pull = 0; wr_data = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        do_reset();
        // R1 reset state
        chk(empty === 1'b1, "R1 empty", DW'(empty), 16'd1);
        chk(full === 1'b0, "R1 full", DW'(full), 16'd0);
        chk(underrun === 1'b0, "R1 underrun", DW'(underrun), 16'd0);
        chk(irq === 1'b0, "R1 irq", DW'(irq), 16'd0);
        chk(pull_data === '0, "R1 pull_data", pull_data, 16'd0);

        // R4 fill to full, then R2 / R3 / R7 drain in order
        for (int i = 0; i < DEP; i++) step(1, DW'(16'hA000 + i), 0, "R4 fill");
        chk(full === 1'b1, "R4 full after 16 writes", DW'(full), 16'd1);
        for (int i = 0; i < DEP; i++) begin
            step(0, '0, 1, "R2 drain");
            chk(pull_data === DW'(16'hA000 + i), "R2 order", pull_data, DW'(16'hA000 + i));
            chk(irq === 1'b1, "R7 irq after pull", DW'(irq), 16'd1);
        end
        chk(empty === 1'b1, "R3 empty after drain", DW'(empty), 16'd1);

        // R5 / R6 underrun replay
        step(0, '0, 1, "R5 underrun");
        chk(pull_data === 16'hA00F, "R5 previous word held", pull_data, 16'hA00F);
        chk(underrun === 1'b1, "R6 flag set", DW'(underrun), 16'd1);
        chk(irq === 1'b0, "R7 no irq on underrun", DW'(irq), 16'd0);
        step(0, '0, 1, "R5 second underrun");
        step(1, 16'h5A5A, 0, "R5 write after underrun");
        step(0, '0, 1, "R5 next word");
        chk(pull_data === 16'h5A5A, "R5 next written word delivered", pull_data, 16'h5A5A);
        for (int i = 0; i < 5; i++) step(0, '0, 0, "R6 idle");
        chk(underrun === 1'b1, "R6 sticky", DW'(underrun), 16'd1);

        // R9 simultaneous on empty: underrun plus write
        step(1, 16'hBEEF, 1, "R9 both on empty");
        chk(empty === 1'b0, "R9 write kept", DW'(empty), 16'd0);
        step(0, '0, 1, "R9 pull");
        chk(pull_data === 16'hBEEF, "R9 word", pull_data, 16'hBEEF);

        // R8 overwrite when full, then R9 at full
        for (int i = 0; i < DEP; i++) step(1, DW'(16'hC000 + i), 0, "R8 fill");
        step(1, 16'hD00D, 0, "R8 overwrite");
        chk(full === 1'b0 && empty === 1'b0, "R8 neither flag", DW'({full, empty}), 16'd0);
        step(0, '0, 1, "R8 read overwritten");
        chk(pull_data === 16'hD00D, "R8 oldest overwritten", pull_data, 16'hD00D);
        step(1, 16'h1111, 0, "R9 refill");
        for (int i = 0; i < DEP - 1; i++) step(1, DW'(i), 0, "R9 refill");
        step(1, 16'h2222, 1, "R9 both at full");
        chk(full === 1'b1, "R9 last access write keeps full", DW'(full), 16'd1);
        chk(irq === 1'b0, "R7 no irq when full after pull", DW'(irq), 16'd0);

        // Random traffic in phases of differing write pressure (R2 R9)
        for (int ph = 0; ph < 6; ph++) begin
            int pw;
            pw = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 50 : 80;
            for (int n = 0; n < 600; n++) begin
                bit we, pl;
                we = ($urandom % 100) < pw;
                pl = ($urandom % 100) < 50;
                step(we, DW'($urandom), pl, "R9 random");
            end
        end

        // R1 reset mid-run clears sticky flag
        do_reset();
        compare("R1 second reset");
        chk(underrun === 1'b0, "R1 underrun cleared", DW'(underrun), 16'd0);

        finish_run();
    end
endmodule